// File: doc/BRIEF.md
# Ten-Bit Leaped LFSR Word Generator

This block produces a stream of 10-bit pseudo-random words from one 31-bit maximal-length shift register built on the polynomial x^31 + x^28 + 1. Each new bit is the XOR of the two tapped bits, and that bit is shifted in at the low end of the register. The register moves ten single-bit steps in every enabled clock, so each word is made entirely of bits that did not exist in the previous word. Stepping once per clock and reading the low ten bits would give words that share nine bits, which makes the next word almost fully predictable.

The ten steps are written as a chain of ten single-step stages inside one combinational net, and synthesis flattens that chain into an XOR network. A seed can be loaded at any time. A zero seed is replaced by all ones, because an all-zero register never leaves zero. The generator suits statistical workloads such as filling histograms or test patterns. It is not meant for cryptographic use.

Top module: `leap_lfsr10`

## Requirements
- R1: After synchronous reset `word_o` is 0, `valid_o` is 0, and the register holds all ones. The first enabled word after reset is therefore the one computed from the all-ones state.
- R2: One enabled clock applies exactly ten serial steps to the register, where bit index 0 is the least significant bit. In each step, fb = s[30] XOR s[27] and the next state is {s[29:0], fb}.
- R3: The output word holds the ten feedback bits made in that clock. The first of them is in bit 9 and the last is in bit 0. Loading the seed 0x4000_0000 and enabling once gives 0x200. The seed 0x0800_0000 gives 0x240.
- R4: While `en_i` and `load_i` are both low, the register and `word_o` hold their values and `valid_o` is 0. The next enabled word continues the sequence as if no pause had occurred.
- R5: `load_i` takes priority over `en_i`. A load cycle copies the seed into the register without advancing it, leaves `word_o` unchanged, and drives `valid_o` to 0 in the following cycle.
- R6: Loading a seed of zero puts all ones into the register, so the register is never zero.
- R7: `valid_o` is 1 in exactly the cycle after each clock in which `en_i` is high and `load_i` is low. The word is registered together with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Seed load strobe |
| seed_i | input | 31 | Seed value copied into the register on load |
| en_i | input | 1 | Advance the register by ten steps and emit a word |
| word_o | output | 10 | Ten newest feedback bits, oldest in the MSB |
| valid_o | output | 1 | A new word was produced by the previous clock |

## Verification
Two single-bit seeds are loaded, one on the top tap and one on the inner tap. These show whether the tap positions are right and whether the bit order in the word runs oldest to newest. Long enabled runs from the reset state are compared with a bit-serial model, and so are runs from a zero seed and from random seeds. These runs expose any miscount in the number of steps per clock. Random pauses and loads, some with enable held high at the same time, separate correct hold behaviour and load priority from a design that advances when it should not.

// File: rtl/leap_pkg.sv
package leap_pkg;
    parameter int unsigned LEAP_STATE_W = 31;
    parameter int unsigned LEAP_WORD_W  = 10;
    parameter int unsigned LEAP_TAP_HI  = 31;
    parameter int unsigned LEAP_TAP_LO  = 28;
endpackage

// File: rtl/leap_step_net.sv
module leap_step_net #(
    parameter int unsigned STATE_W = 31,
    parameter int unsigned STEPS   = 10,
    parameter int unsigned TAP_HI  = 31,
    parameter int unsigned TAP_LO  = 28
) (
    input  logic [STATE_W-1:0] cur_state,
    output logic [STATE_W-1:0] nxt_state,
    output logic [STEPS-1:0]   new_bits
);
    localparam int unsigned HI_IDX = TAP_HI - 1;
    localparam int unsigned LO_IDX = TAP_LO - 1;

    logic [STATE_W-1:0] chain [STEPS+1];
    logic [STEPS-1:0]   fb;

    assign chain[0] = cur_state;

    for (genvar i = 0; i < STEPS; i++) begin : g_stage
        assign fb[STEPS-1-i] = chain[i][HI_IDX] ^ chain[i][LO_IDX];
        assign chain[i+1]    = {chain[i][STATE_W-2:0], fb[STEPS-1-i]};
    end

    assign nxt_state = chain[STEPS];
    assign new_bits  = fb;
endmodule

// File: rtl/leap_seed_fix.sv
module leap_seed_fix #(
    parameter int unsigned STATE_W = 31
) (
    input  logic [STATE_W-1:0] raw_seed,
    output logic [STATE_W-1:0] safe_seed
);
    localparam logic [STATE_W-1:0] FILL = '1;

    always_comb begin
        if (raw_seed == '0) safe_seed = FILL;
        else                safe_seed = raw_seed;
    end
endmodule

// File: rtl/leap_lfsr10.sv
module leap_lfsr10 #(
    parameter int unsigned STATE_W = leap_pkg::LEAP_STATE_W,
    parameter int unsigned WORD_W  = leap_pkg::LEAP_WORD_W,
    parameter int unsigned TAP_HI  = leap_pkg::LEAP_TAP_HI,
    parameter int unsigned TAP_LO  = leap_pkg::LEAP_TAP_LO
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [STATE_W-1:0] seed_i,
    input  logic               en_i,
    output logic [WORD_W-1:0]  word_o,
    output logic               valid_o
);
    localparam logic [STATE_W-1:0] RST_STATE = '1;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [WORD_W-1:0]  word;
        logic               valid;
    } regs_t;

    regs_t r_d, r_q;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] leap_state;
    logic [WORD_W-1:0]  leap_bits;
    logic [STATE_W-1:0] seed_ok;

    assign state_q = r_q.state;

    leap_step_net #(
        .STATE_W(STATE_W),
        .STEPS  (WORD_W),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO)
    ) u_net (
        .cur_state(r_q.state),
        .nxt_state(leap_state),
        .new_bits (leap_bits)
    );

    leap_seed_fix #(
        .STATE_W(STATE_W)
    ) u_seed (
        .raw_seed (seed_i),
        .safe_seed(seed_ok)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (load_i) begin
            r_d.state = seed_ok;
        end else if (en_i) begin
            r_d.state = leap_state;
            r_d.word  = leap_bits;
            r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= RST_STATE;
            r_q.word  <= '0;
            r_q.valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_o  = r_q.word;
    assign valid_o = r_q.valid;
endmodule

// File: rtl/leap_lfsr10_chk.sv
module leap_lfsr10_chk #(
    parameter int unsigned STATE_W = 31,
    parameter int unsigned WORD_W  = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               load_i,
    input logic [STATE_W-1:0] seed_i,
    input logic               en_i,
    input logic [WORD_W-1:0]  word_o,
    input logic               valid_o,
    input logic [STATE_W-1:0] state_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!valid_o && word_o == '0 && state_q == '1));

    a_r2_shift_by_word: assert property (@(posedge clk) disable iff (rst)
        (en_i && !load_i) |=> state_q[STATE_W-1:WORD_W] == $past(state_q[STATE_W-1-WORD_W:0]));

    a_r3_word_is_low_bits: assert property (@(posedge clk) disable iff (rst)
        (en_i && !load_i) |=> word_o == state_q[WORD_W-1:0]);

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> ($stable(word_o) && $stable(state_q) && !valid_o));

    a_r5_load_copies_seed: assert property (@(posedge clk) disable iff (rst)
        (load_i && seed_i != '0) |=> (state_q == $past(seed_i) && $stable(word_o) && !valid_o));

    a_r6_never_zero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    a_r7_valid_after_step: assert property (@(posedge clk) disable iff (rst)
        (en_i && !load_i) |=> valid_o);
endmodule

bind leap_lfsr10 leap_lfsr10_chk #(
    .STATE_W(STATE_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .seed_i (seed_i),
    .en_i   (en_i),
    .word_o (word_o),
    .valid_o(valid_o),
    .state_q(state_q)
);

// File: tb/sim_leap_lfsr10.sv
module sim_leap_lfsr10;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [30:0] seed_i = '0;
    logic        en_i = 1'b0;
    logic [9:0]  word_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [30:0] m_state;
    logic [9:0]  m_word;
    logic        m_valid;

    always #10 clk = ~clk;

    leap_lfsr10 u0 (
        .clk(clk), .rst(rst), .load_i(load_i), .seed_i(seed_i),
        .en_i(en_i), .word_o(word_o), .valid_o(valid_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [30:0] fix_seed(input logic [30:0] s);
        return (s == '0) ? '1 : s;
    endfunction

    task automatic model_edge(input bit r, input bit ld, input logic [30:0] sd, input bit en);
        logic fb;
        if (r) begin
            m_state = '1; m_word = '0; m_valid = 1'b0;
        end else if (ld) begin
            m_state = fix_seed(sd); m_valid = 1'b0;
        end else if (en) begin
            for (int k = 0; k < 10; k++) begin
                fb = m_state[30] ^ m_state[27];
                m_state = {m_state[29:0], fb};
                m_word  = {m_word[8:0], fb};
            end
            m_valid = 1'b1;
        end else begin
            m_valid = 1'b0;
        end
    endtask

    task automatic cycle(input bit ld, input logic [30:0] sd, input bit en,
                         input string wreq, input string vreq);
        load_i = ld; seed_i = sd; en_i = en;
        @(posedge clk);
        model_edge(rst, ld, sd, en);
        @(negedge clk);
        check(wreq, {22'd0, word_o}, {22'd0, m_word});
        check(vreq, {31'd0, valid_o}, {31'd0, m_valid});
    endtask

    initial begin
        @(negedge clk);
        @(posedge clk);
        model_edge(1'b1, 1'b0, '0, 1'b0);
        @(negedge clk);
        check("R1", {22'd0, word_o}, 32'd0);
        check("R1", {31'd0, valid_o}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < 40; i++) cycle(1'b0, '0, 1'b1, "R1", "R7");

        cycle(1'b1, 31'h4000_0000, 1'b0, "R5", "R5");
        cycle(1'b0, '0, 1'b1, "R3", "R7");
        check("R3", {22'd0, word_o}, 32'h200);
        cycle(1'b1, 31'h0800_0000, 1'b1, "R5", "R5");
        cycle(1'b0, '0, 1'b1, "R3", "R7");
        check("R3", {22'd0, word_o}, 32'h240);

        cycle(1'b1, '0, 1'b0, "R6", "R5");
        for (int i = 0; i < 20; i++) cycle(1'b0, '0, 1'b1, "R6", "R7");

        for (int i = 0; i < 5; i++) cycle(1'b0, '0, 1'b0, "R4", "R4");
        for (int i = 0; i < 5; i++) cycle(1'b0, '0, 1'b1, "R4", "R7");

        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom % 100;
            logic [30:0] s = 31'($urandom);
            if ((i % 500) == 7) s = '0;
            if (r < 4)       cycle(1'b1, s, 1'($urandom), "R5", "R5");
            else if (r < 20) cycle(1'b0, s, 1'b0, "R4", "R4");
            else             cycle(1'b0, s, 1'b1, "R2", "R7");
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule